// File: doc/BRIEF.md
# Masked Packed Vector XOR Unit

This block computes a lane-wise bitwise XOR of two 512-bit vector operands divided into eight 64-bit lanes. A length code selects whether 128, 256 or 512 bits take part. An eight-bit lane mask decides which lanes receive the XOR result. A lane left out by the mask either keeps its previous destination value (merge) or is cleared (zero). When the second operand comes from memory, a broadcast option copies its low 64 bits into every lane.

Three operating modes exist:
- **Legacy two-operand mode.** The old destination is the first operand. Only the low 128 bits are rewritten, and every bit above keeps its old value.
- **Unmasked three-operand mode.** Every lane within the selected length is written.
- **Masked three-operand mode.** Lanes are written under the mask.

In both three-operand modes, destination bits from the selected length up to bit 511 are cleared. Bit patterns are treated as raw data, so NaN or denormal encodings raise no flags.

The caller presents the operands, the old destination value and the controls together with a valid strobe. A small control FSM has two states:
- **IDLE.** Stays in IDLE while the strobe is low. On a strobe it takes the transition CAPTURE and moves to RESULT.
- **RESULT.** Raises the output valid flag for one cycle. It then either takes CAPTURE again, when a new strobe arrives in that cycle, or returns to IDLE through the transition DRAIN.

The new destination value is therefore registered and appears exactly one clock after the strobe. An unsupported combination of mode and length raises an illegal flag, and the destination returned is the old value.

Top module: `vxor_lane_unit`

## Requirements
- R1: `res_valid` is 0 after reset. It is 1 in exactly the cycle after each cycle where `in_valid` is 1, and 0 otherwise. All result outputs change only together with a raised `res_valid`.
- R2: `vlen` encoding: 0 = 128 bits (2 lanes), 1 = 256 bits (4 lanes), 2 = 512 bits (8 lanes), 3 = reserved. Lane j occupies bits [64j+63:64j].
- R3: `mode` encoding: 0 = legacy, 1 = unmasked three-operand, 2 = masked three-operand, 3 = reserved. In modes 1 and 2, an active lane j within the length yields `src1` lane j XOR the second-operand lane j.
- R4: In mode 2, lane j is active when `kmask[j]` is 1. When `zero_mask` is 0, an inactive lane within the length returns the `old_dst` lane. When `zero_mask` is 1, it returns zero.
- R5: When `bcast` and `from_mem` are both 1 in mode 2, every active lane uses `src2[63:0]` as its second operand.
- R6: In modes 1 and 2, result bits from the selected length up to 511 are zero.
- R7: In mode 0, bits [127:0] are `old_dst[127:0]` XOR `src2[127:0]`, and bits [511:128] equal `old_dst[511:128]`. `src1` has no effect in this mode.
- R8: In modes 0 and 1, `kmask` and `zero_mask` have no effect. `bcast` has no effect in modes 0 and 1, and it has no effect whenever `from_mem` is 0.
- R9: The combination is illegal when `mode` is 3, when `vlen` is 3, or when `vlen` is 2 and `mode` is not 2. For an illegal combination, `res_illegal` is 1 and `res_dst` equals `old_dst`. Otherwise `res_illegal` is 0.
- R10: Legacy mode accepts `vlen` 0 or 1. Its result is the same for both values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Operating mode |
| vlen | input | 2 | Vector length code |
| kmask | input | 8 | Per-lane write mask |
| zero_mask | input | 1 | 1 = zero inactive lanes, 0 = merge |
| bcast | input | 1 | Broadcast request |
| from_mem | input | 1 | Second operand comes from memory |
| src1 | input | 512 | First source |
| src2 | input | 512 | Second source |
| old_dst | input | 512 | Previous destination value |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_illegal | output | 1 | Unsupported combination flag |
| res_dst | output | 512 | New destination value |

## Verification
The checker module verifies the following on every cycle:
- The one-cycle valid timing.
- That result outputs hold steady between valid pulses.
- That an illegal result echoes the captured old destination.
- That three-operand results are zero above the selected length.
- That legacy results keep the upper old bits.

Only the bench's scenarios can show the lane data itself:
- Correct merge versus zero selection.
- Broadcast gating by mode and memory flag.
- That ignored controls have no effect.

The bench checks these against an independently computed reference.

// File: rtl/vxor_pkg.sv
package vxor_pkg;
    localparam int LANE_W    = 64;
    localparam int NUM_LANES = 8;
    localparam int VEC_W     = LANE_W * NUM_LANES;

    typedef enum logic [1:0] {
        MD_LEGACY = 2'd0,
        MD_PLAIN  = 2'd1,
        MD_MASKED = 2'd2,
        MD_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

    typedef struct packed {
        logic             legacy;
        logic             use_mask;
        logic             zero_mask;
        logic             bcast_on;
        logic             illegal;
        logic [NUM_LANES-1:0] in_len;
    } lane_ctl_t;
endpackage

// File: rtl/vxor_ctl_decode.sv
module vxor_ctl_decode
    import vxor_pkg::*;
#(
    parameter int N_LANES = NUM_LANES
) (
    input  logic [1:0]         mode,
    input  logic [1:0]         vlen,
    input  logic               zero_mask,
    input  logic               bcast,
    input  logic               from_mem,
    output lane_ctl_t          ctl
);
    always_comb begin
        ctl = '0;
        ctl.legacy    = (mode == MD_LEGACY);
        ctl.use_mask  = (mode == MD_MASKED);
        ctl.zero_mask = zero_mask & (mode == MD_MASKED);
        ctl.bcast_on  = bcast & from_mem & (mode == MD_MASKED);
        ctl.illegal   = (mode == MD_RSVD) || (vlen == VL_RSVD) ||
                        ((vlen == VL_512) && (mode != MD_MASKED));
        unique case (vlen)
            VL_128:  ctl.in_len = N_LANES'(8'b0000_0011);
            VL_256:  ctl.in_len = N_LANES'(8'b0000_1111);
            VL_512:  ctl.in_len = N_LANES'(8'b1111_1111);
            default: ctl.in_len = '0;
        endcase
        // legacy always writes exactly the low 128 bits
        if (mode == MD_LEGACY) ctl.in_len = N_LANES'(8'b0000_0011);
    end
endmodule

// File: rtl/vxor_lane.sv
module vxor_lane
    import vxor_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic         in_len,
    input  logic         mask_bit,
    input  logic         legacy,
    input  logic         use_mask,
    input  logic         zero_mask,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] old,
    output logic [W-1:0] y
);
    logic active;
    always_comb begin
        active = in_len & (~use_mask | mask_bit);
        if (legacy) begin
            y = in_len ? (old ^ b) : old;
        end else if (!in_len) begin
            y = '0;
        end else if (active) begin
            y = a ^ b;
        end else begin
            y = zero_mask ? '0 : old;
        end
    end
endmodule

// File: rtl/vxor_lane_unit.sv
module vxor_lane_unit
    import vxor_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   mode,
    input  logic [1:0]   vlen,
    input  logic [7:0]   kmask,
    input  logic         zero_mask,
    input  logic         bcast,
    input  logic         from_mem,
    input  logic [511:0] src1,
    input  logic [511:0] src2,
    input  logic [511:0] old_dst,
    output logic         res_valid,
    output logic         res_illegal,
    output logic [511:0] res_dst
);
    localparam int LW = LANE_W;
    localparam int NL = NUM_LANES;

    state_e    state_q, state_d;
    lane_ctl_t ctl;
    logic [VEC_W-1:0] lane_out;
    logic [VEC_W-1:0] next_dst;

    vxor_ctl_decode #(.N_LANES(NL)) u_dec (
        .mode(mode), .vlen(vlen), .zero_mask(zero_mask),
        .bcast(bcast), .from_mem(from_mem), .ctl(ctl)
    );

    for (genvar j = 0; j < NL; j++) begin : g_lane
        logic [LW-1:0] b_sel;
        logic [LW-1:0] a_sel;
        assign b_sel = ctl.bcast_on ? src2[LW-1:0] : src2[j*LW +: LW];
        assign a_sel = ctl.legacy ? old_dst[j*LW +: LW] : src1[j*LW +: LW];
        vxor_lane #(.W(LW)) u_lane (
            .in_len(ctl.in_len[j]), .mask_bit(kmask[j]),
            .legacy(ctl.legacy), .use_mask(ctl.use_mask),
            .zero_mask(ctl.zero_mask),
            .a(a_sel), .b(b_sel), .old(old_dst[j*LW +: LW]),
            .y(lane_out[j*LW +: LW])
        );
    end

    assign next_dst = ctl.illegal ? old_dst : lane_out;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;   // CAPTURE
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;   // CAPTURE / DRAIN
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            res_illegal <= 1'b0;
            res_dst     <= '0;
        end else if (in_valid) begin
            res_illegal <= ctl.illegal;
            res_dst     <= next_dst;
        end
    end

    assign res_valid = (state_q == ST_RESULT);
endmodule

// File: rtl/vxor_lane_unit_chk.sv
module vxor_lane_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   mode,
    input logic [1:0]   vlen,
    input logic [511:0] old_dst,
    input logic         res_valid,
    input logic         res_illegal,
    input logic [511:0] res_dst
);
    logic         started;
    logic [1:0]   mode_q, vlen_q;
    logic [511:0] old_q;
    logic [511:0] hi_mask;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b1;
        if (in_valid) begin
            mode_q <= mode;
            vlen_q <= vlen;
            old_q  <= old_dst;
        end
    end
    always_comb begin
        unique case (vlen_q)
            2'd0:    hi_mask = {{384{1'b1}}, {128{1'b0}}};
            2'd1:    hi_mask = {{256{1'b1}}, {256{1'b0}}};
            default: hi_mask = '0;
        endcase
    end

    // R1
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst || !started)
        in_valid |=> res_valid);
    // R1
    valid_only_after_strobe_chk: assert property (@(posedge clk) disable iff (rst || !started)
        !in_valid |=> !res_valid);
    // R1
    result_stable_chk: assert property (@(posedge clk) disable iff (rst || !started)
        !res_valid |-> $stable(res_dst) && $stable(res_illegal));
    // R9
    illegal_echo_chk: assert property (@(posedge clk) disable iff (rst || !started)
        (res_valid && res_illegal) |-> res_dst == old_q);
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst || !started)
        (res_valid && !res_illegal && mode_q != 2'd0) |-> (res_dst & hi_mask) == '0);
    // R7
    legacy_upper_chk: assert property (@(posedge clk) disable iff (rst || !started)
        (res_valid && !res_illegal && mode_q == 2'd0) |-> res_dst[511:128] == old_q[511:128]);
endmodule

bind vxor_lane_unit vxor_lane_unit_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .vlen(vlen),
    .old_dst(old_dst), .res_valid(res_valid), .res_illegal(res_illegal),
    .res_dst(res_dst)
);

// File: tb/tb_vxor_lane_unit.sv
`timescale 1ns/1ps
module tb_vxor_lane_unit;
    logic clk = 0;
    logic rst;
    logic in_valid;
    logic [1:0] mode, vlen;
    logic [7:0] kmask;
    logic zero_mask, bcast, from_mem;
    logic [511:0] src1, src2, old_dst;
    logic res_valid, res_illegal;
    logic [511:0] res_dst;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vxor_lane_unit dut (.*);

    function automatic logic [511:0] ref_dst(input logic [1:0] md, input logic [1:0] vl,
        input logic [7:0] k, input logic z, input logic bc, input logic fm,
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] o);
        logic [511:0] r;
        int nl;
        if (md == 3 || vl == 3 || (vl == 2 && md != 2)) return o;
        if (md == 0) begin
            r = o;
            r[127:0] = o[127:0] ^ b[127:0];
            return r;
        end
        nl = (vl == 0) ? 2 : (vl == 1) ? 4 : 8;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            logic [63:0] bl;
            bl = (md == 2 && bc && fm) ? b[63:0] : b[j*64 +: 64];
            if (j < nl) begin
                if (md == 1 || k[j]) r[j*64 +: 64] = a[j*64 +: 64] ^ bl;
                else r[j*64 +: 64] = z ? 64'd0 : o[j*64 +: 64];
            end
        end
        return r;
    endfunction

    function automatic logic ref_ill(input logic [1:0] md, input logic [1:0] vl);
        return md == 3 || vl == 3 || (vl == 2 && md != 2);
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [1:0] md, input logic [1:0] vl,
        input logic [7:0] k, input logic z, input logic bc, input logic fm,
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] o);
        logic [511:0] e;
        e = ref_dst(md, vl, k, z, bc, fm, a, b, o);
        @(negedge clk);
        in_valid = 1; mode = md; vlen = vl; kmask = k; zero_mask = z;
        bcast = bc; from_mem = fm; src1 = a; src2 = b; old_dst = o;
        @(negedge clk);
        in_valid = 0;
        chk({tag, " R1 valid"}, {511'd0, res_valid}, 512'd1);
        chk({tag, " R9 illegal"}, {511'd0, res_illegal}, {511'd0, ref_ill(md, vl)});
        chk({tag, " dst"}, res_dst, e);
        @(negedge clk);
        chk({tag, " R1 valid drop"}, {511'd0, res_valid}, 512'd0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [511:0] a, b, o, r0, r1;
        void'($urandom(32'h5eed_1234));
        rst = 1; in_valid = 0; mode = 0; vlen = 0; kmask = 0; zero_mask = 0;
        bcast = 0; from_mem = 0; src1 = 0; src2 = 0; old_dst = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset valid", {511'd0, res_valid}, 512'd0);
        a = rnd512(); b = rnd512(); o = rnd512();
        // R3 R6 unmasked 128/256
        run_op("R3 R6 plain128", 1, 0, 8'h00, 0, 0, 0, a, b, o);
        run_op("R3 R6 plain256", 1, 1, 8'h00, 1, 0, 0, a, b, o);
        // R2 R4 masked merge/zero 512
        run_op("R2 R4 merge512", 2, 2, 8'hA5, 0, 0, 0, a, b, o);
        run_op("R4 zero512", 2, 2, 8'h5A, 1, 0, 0, a, b, o);
        run_op("R4 R6 merge256", 2, 1, 8'hF6, 0, 0, 0, a, b, o);
        // R5 broadcast
        run_op("R5 bcast", 2, 2, 8'hFF, 0, 1, 1, a, b, o);
        run_op("R8 bcast nomem", 2, 2, 8'hFF, 0, 1, 0, a, b, o);
        run_op("R8 bcast plain", 1, 1, 8'h00, 0, 1, 1, a, b, o);
        // R7 R10 legacy
        run_op("R7 legacy128", 0, 0, 8'h00, 0, 0, 0, a, b, o);
        run_op("R10 legacy256", 0, 1, 8'hFF, 1, 1, 1, a, b, o);
        // R7: src1 no effect in legacy
        run_op("R7 legacy src1", 0, 0, 8'h00, 0, 0, 0, ~a, b, o);
        // R8 mask ignored in mode 1
        run_op("R8 plain mask", 1, 1, 8'h00, 1, 0, 0, a, b, o);
        // R9 illegal
        run_op("R9 plain512", 1, 2, 8'hFF, 0, 0, 0, a, b, o);
        run_op("R9 legacy512", 0, 2, 8'hFF, 0, 0, 0, a, b, o);
        run_op("R9 mode3", 3, 0, 8'hFF, 0, 0, 0, a, b, o);
        run_op("R9 vlen3", 2, 3, 8'hFF, 0, 0, 0, a, b, o);
        // R8/R10 direct compare: legacy result equal across vlen and mask
        run_op("R10 a", 0, 0, 8'h00, 0, 0, 0, a, b, o); r0 = res_dst;
        run_op("R10 b", 0, 1, 8'h3C, 1, 1, 1, a, b, o); r1 = res_dst;
        chk("R10 legacy vlen same", r1, r0);
        // random
        for (int n = 0; n < 300; n++) begin
            run_op("R3 R4 R5 rand", 2'($urandom), 2'($urandom), 8'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), rnd512(), rnd512(), rnd512());
        end
        // back-to-back strobes R1
        @(negedge clk);
        in_valid = 1; mode = 1; vlen = 0; src1 = a; src2 = b; old_dst = o;
        @(negedge clk);
        mode = 2; vlen = 2; kmask = 8'h0F; zero_mask = 1; bcast = 0;
        chk("R1 b2b valid1", {511'd0, res_valid}, 512'd1);
        chk("R1 b2b dst1", res_dst, ref_dst(1, 0, 0, 0, 0, 0, a, b, o));
        @(negedge clk);
        in_valid = 0;
        chk("R1 b2b valid2", {511'd0, res_valid}, 512'd1);
        chk("R1 b2b dst2", res_dst, ref_dst(2, 2, 8'h0F, 1, 0, 0, a, b, o));
        @(negedge clk);
        chk("R1 b2b drop", {511'd0, res_valid}, 512'd0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule